// File: doc/BRIEF.md
# Square-Wave Quadrature Phase-Select Modulator

This block is a fully digital QPSK transmitter front end. It never builds a sinusoid. A two-bit Johnson counter runs at four times the carrier rate and produces one square carrier in four quarter-period offsets. Serial payload bits are paired into symbols, and each symbol picks one of those four square waves for the single-bit output. Removing the harmonics of the square wave is left to an analog filter outside the chip.

A programmable divider sets the bit rate and tells the data source when each bit is taken through a one-cycle strobe. A completed symbol waits in a holding register. It reaches the phase selector only when the carrier is about to start a new period, so every switch happens on a period boundary. With a 20 MHz system clock the carrier is 5 MHz.

Top module: `qpsk_phase_mod`

## Requirements
- R1: The carrier period is 4 clocks, counted as quarters q = 0..3 from the cycle after reset. The phase p (0..3 = 0°, 90°, 180°, 270°) is high in quarter q exactly when (q − p) mod 4 is 0 or 1. Each step of phase therefore delays the 0° wave by one clock.
- R2: A symbol value of 00 selects phase 0 (0°), 01 selects phase 1 (90°), 10 selects phase 2 (180°) and 11 selects phase 3 (270°).
- R3: `bit_tick` is high for one clock in every `BIT_DIV` clocks. It is high in cycle k after reset (k = clock edges since release) exactly when k mod `BIT_DIV` = `BIT_DIV` − 1.
- R4: `data_in` is captured on each clock edge that ends a `bit_tick` cycle. The first bit of a pair is the symbol MSB (in-phase) and the second is the LSB (quadrature).
- R5: The output phase changes only at a carrier boundary. A new selection first appears in quarter 0.
- R6: While `rst_n` is low, and right after it is released, the output follows the 0° wave. Reset clears the quarter counter, the bit divider, any half-received symbol and the held symbol.
- R7: A completed symbol takes effect at the first boundary whose preceding quarter-3 cycle comes at or after the cycle the symbol completes. Until then the previous phase is kept.
- R8: `data_in` has no effect in cycles where `bit_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four times the carrier frequency |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in sync with `clk` |
| data_in | input | 1 | Serial payload bit, sampled when `bit_tick` is high |
| bit_tick | output | 1 | One-cycle strobe marking the cycle whose edge captures `data_in` |
| mod_out | output | 1 | Square-wave carrier in the selected phase |

## Verification
The assertions assume that `BIT_DIV` is at least 2, so two strobes never sit in adjacent cycles. They also assume that `rst_n` is released in step with the clock, so the counter walks its four-state ring one step per cycle from quarter 0. The stimulus releases reset only on a falling clock edge. It drives `data_in` only between rising edges, with real payload in strobe cycles and random values elsewhere. The expected output is computed from cycle counts since reset, using the boundary rule of R7.

// File: rtl/qpsk_pkg.sv
package qpsk_pkg;
  // Carrier phase index: number of quarter periods of delay behind 0 degrees.
  typedef enum logic [1:0] {
    PH_000 = 2'd0,
    PH_090 = 2'd1,
    PH_180 = 2'd2,
    PH_270 = 2'd3
  } phase_e;

  localparam int unsigned NUM_PHASES = 4;
  // Ring state held in the last quarter of a carrier period.
  localparam logic [1:0] RING_LAST  = 2'b10;
  localparam logic [1:0] RING_FIRST = 2'b00;
endpackage

// File: rtl/qpsk_quad_carrier.sv
module qpsk_quad_carrier
  import qpsk_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [1:0]            ring,
  output logic [NUM_PHASES-1:0] phases
);
  logic [1:0] ring_q, ring_d;

  // Two-bit Johnson ring: 00 -> 01 -> 11 -> 10 -> 00
  always_comb begin
    ring_d = {ring_q[0], ~ring_q[1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= RING_FIRST;
    else        ring_q <= ring_d;
  end

  // Each phase is one quarter later than the one before it
  always_comb begin
    phases[PH_000] = ~ring_q[1];
    phases[PH_090] =  ring_q[0];
    phases[PH_180] =  ring_q[1];
    phases[PH_270] = ~ring_q[0];
  end

  assign ring = ring_q;

  // R1: the ring moves exactly one bit per clock
  assert_ring_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(ring_q ^ $past(ring_q)) == 1));
endmodule

// File: rtl/qpsk_bit_clock.sv
module qpsk_bit_clock #(
  parameter int unsigned BIT_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_tick
);
  localparam int unsigned CW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bit_tick = wrap;

  // R3: strobe never lasts more than one cycle
  assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
endmodule

// File: rtl/qpsk_dibit_asm.sv
module qpsk_dibit_asm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       data_in,
  input  logic       take,
  output logic [1:0] held,
  output logic       held_valid
);
  logic       half_q, half_d;
  logic       first_q, first_d;
  logic [1:0] held_q, held_d;
  logic       hv_q, hv_d;

  always_comb begin
    half_d  = half_q;
    first_d = first_q;
    held_d  = held_q;
    hv_d    = hv_q & ~take;
    if (bit_tick) begin
      if (!half_q) begin
        first_d = data_in;         // in-phase bit, symbol MSB
        half_d  = 1'b1;
      end else begin
        held_d  = {first_q, data_in};
        hv_d    = 1'b1;
        half_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      first_q <= 1'b0;
      held_q  <= 2'b00;
      hv_q    <= 1'b0;
    end else begin
      half_q  <= half_d;
      first_q <= first_d;
      held_q  <= held_d;
      hv_q    <= hv_d;
    end
  end

  assign held       = held_q;
  assign held_valid = hv_q;

  // R4: a symbol becomes ready only on the second strobe of a pair
  assert_pair_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv_q) |-> ($past(bit_tick) && $past(half_q)));
endmodule

// File: rtl/qpsk_phase_mux.sv
module qpsk_phase_mux
  import qpsk_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            ring,
  input  logic [NUM_PHASES-1:0] phases,
  input  logic [1:0]            held,
  input  logic                  held_valid,
  output logic                  take,
  output logic                  mod_out
);
  phase_e sel_q, sel_d;

  assign take = held_valid && (ring == RING_LAST);

  always_comb begin
    sel_d = take ? phase_e'(held) : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= PH_000;
    else        sel_q <= sel_d;
  end

  assign mod_out = phases[sel_q];

  // R5: a new selection first shows in quarter 0
  assert_switch_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> (ring == RING_FIRST));

  // R7: a selection change needs a waiting symbol
  assert_switch_needs_symbol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(held_valid));
endmodule

// File: rtl/qpsk_phase_mod.sv
module qpsk_phase_mod
  import qpsk_pkg::*;
#(
  parameter int unsigned BIT_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_in,
  output logic bit_tick,
  output logic mod_out
);
  logic [1:0]            ring;
  logic [NUM_PHASES-1:0] phases;
  logic [1:0]            held;
  logic                  held_valid;
  logic                  take;

  qpsk_quad_carrier u_carrier (
    .clk    (clk),
    .rst_n  (rst_n),
    .ring   (ring),
    .phases (phases)
  );

  qpsk_bit_clock #(.BIT_DIV(BIT_DIV)) u_bitclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick)
  );

  qpsk_dibit_asm u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .data_in    (data_in),
    .take       (take),
    .held       (held),
    .held_valid (held_valid)
  );

  qpsk_phase_mux u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring       (ring),
    .phases     (phases),
    .held       (held),
    .held_valid (held_valid),
    .take       (take),
    .mod_out    (mod_out)
  );
endmodule

// File: tb/qpsk_phase_mod_test.sv
`timescale 1ns/1ps
module qpsk_phase_mod_test;
  localparam int DIV = 10;
  localparam int NV  = 12;
  // {symbol, expected phase index} per R2
  localparam logic [3:0] VEC [NV] = '{
    4'b00_00, 4'b01_01, 4'b10_10, 4'b11_11,
    4'b01_01, 4'b10_10, 4'b11_11, 4'b00_00,
    4'b10_10, 4'b01_01, 4'b00_00, 4'b11_11
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_in = 1'b0;
  logic bit_tick, mod_out;
  int k = 0;
  int base = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  qpsk_phase_mod #(.BIT_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in),
    .bit_tick(bit_tick), .mod_out(mod_out)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) k <= 0;
    else        k <= k + 1;

  function automatic logic [1:0] sym_of(int j);
    return (base + j < NV) ? VEC[base + j][3:2] : 2'b00;
  endfunction

  function automatic int phase_of(int j);
    return (base + j < NV) ? int'(VEC[base + j][1:0]) : 0;
  endfunction

  // R7: symbol j completes at k=(2j+2)*DIV, shows at next multiple of 4 above it
  function automatic int exp_phase(int kk);
    int p = 0;
    for (int j = 0; j < 64; j++) begin
      int eff = ((((2 * j + 2) * DIV) / 4) + 1) * 4;
      if (eff <= kk) p = phase_of(j);
      else break;
    end
    return p;
  endfunction

  function automatic logic exp_out(int kk, int p);
    return ((((kk % 4) - p + 4) % 4) < 2);
  endfunction

  task automatic check(logic got, logic exp, string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", req, got, exp, k);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Walk the vector table: check every cycle, feed bits on strobes, noise elsewhere
  task automatic run_cycles(int n);
    repeat (n) begin
      @(negedge clk);
      check(mod_out, exp_out(k, exp_phase(k)), "R1 R2 R4 R5 R7 R8");
      check(bit_tick, logic'((k % DIV) == DIV - 1), "R3");
      if ((k % DIV) == DIV - 1) begin
        int b = k / DIV;
        logic [1:0] s = sym_of(b / 2);
        data_in = (b % 2 == 0) ? s[1] : s[0];
      end else begin
        data_in = logic'($urandom % 2);   // R8: must be ignored
      end
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      data_in = logic'($urandom % 2);
      check(mod_out, 1'b1, "R6 reset output");
      check(bit_tick, 1'b0, "R6 reset strobe");
    end
    rst_n = 1'b1;
    run_cycles(2 * DIV * NV + 40);

    // Directed: reset in mid-run, then a second stream from the table middle
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(mod_out, 1'b1, "R6 async clear");
    check(bit_tick, 1'b0, "R6 async clear strobe");
    base = 6;
    repeat (2) begin
      @(negedge clk);
      check(mod_out, 1'b1, "R6 held reset");
    end
    rst_n = 1'b1;
    run_cycles(2 * DIV * (NV - base) + 40);
    finish_run();
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule